// File: doc/BRIEF.md
# Clock-Qualified Memory Map Decoder

This block turns the 16-bit address bus of a small 8-bit processor system into active-low chip selects. The upper half of the space goes to program ROM and the bottom quarter to RAM. The quarter between them is cut into 4K windows for a sound generator, a display parallel adapter and a key-matrix parallel adapter. The lowest 4K window of that quarter is an I/O window. By default it is split into a 2K serial-adapter half and a 2K general-I/O half. A parameter merges the two halves into one 4K general-I/O select.

Each device sees only its own window, so a device with few register lines appears repeated throughout that window. All selects are combinational from the address. The RAM select is the only one also qualified by the processor's phase-2 clock: it is asserted only while that clock is high. A population mask drops regions that a board leaves unfitted. An address that falls in a dropped region raises an `unmapped` flag instead of a select.

Top module: `mmap_decoder`

## Requirements
- R1: An address with bit 15 set (0x8000–0xFFFF) asserts `rom_cs_n` low.
- R2: An address with bits 15 and 14 clear (0x0000–0x3FFF) asserts `ram_cs_n` low only while `phi2` is high. While `phi2` is low, `ram_cs_n` stays high.
- R3: 0x7000–0x7FFF asserts `snd_cs_n`, 0x6000–0x6FFF asserts `disp_cs_n`, and 0x5000–0x5FFF asserts `keys_cs_n`.
- R4: With `SPLIT_IO`=1, 0x4800–0x4FFF asserts `gio_cs_n` and 0x4000–0x47FF asserts `ser_cs_n`. Address bit 11 chooses between them.
- R5: With `SPLIT_IO`=0, all of 0x4000–0x4FFF asserts `gio_cs_n` and `ser_cs_n` never goes low.
- R6: At no address and clock level is more than one select low. With `phi2` high, exactly one of the seven selects is low or `unmapped` is high.
- R7: `POPULATED` has one bit per region: bit 0 ROM, 1 RAM, 2 sound, 3 display, 4 keys, 5 general I/O, 6 serial. An address in a region whose bit is 0 leaves every select high and drives `unmapped` high. Otherwise `unmapped` is low.
- R8: Every output except `ram_cs_n` is independent of `phi2`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| addr | input | 16 | Processor address bus |
| phi2 | input | 1 | Processor phase-2 clock; high is the data phase |
| rom_cs_n | output | 1 | ROM select, active low |
| ram_cs_n | output | 1 | RAM select, active low, only during phase 2 high |
| snd_cs_n | output | 1 | Sound generator select, active low |
| disp_cs_n | output | 1 | Display parallel adapter select, active low |
| keys_cs_n | output | 1 | Key-matrix parallel adapter select, active low |
| gio_cs_n | output | 1 | General I/O select, active low |
| ser_cs_n | output | 1 | Serial adapter select, active low |
| unmapped | output | 1 | High when the address lies in an unfitted region |

## Verification
Address decode and clock qualification act together: one address can be a RAM hit while `phi2` is either high or low. The bench holds each of the 65536 addresses for a full `phi2` period and samples once in each phase. A behavioural range model judges the high phase, where exactly one output must be active. It also judges the low phase, where RAM addresses must show no select at all and every other output must match its high-phase value. Three instances are checked: split I/O, merged I/O, and a partly unfitted map, which covers the interaction between the population mask and the `unmapped` flag.

// File: rtl/mmap_pkg.sv
package mmap_pkg;

   localparam int MAP_AW = 16;
   localparam int NUM_RG = 7;

   typedef enum int {
      RG_ROM  = 0,
      RG_RAM  = 1,
      RG_SND  = 2,
      RG_DISP = 3,
      RG_KEYS = 4,
      RG_GIO  = 5,
      RG_SER  = 6
   } region_e;

   // lowest address of each window
   function automatic logic [MAP_AW-1:0] rg_base(input int g, input bit split);
      case (g)
         RG_ROM:  return 16'h8000;
         RG_RAM:  return 16'h0000;
         RG_SND:  return 16'h7000;
         RG_DISP: return 16'h6000;
         RG_KEYS: return 16'h5000;
         RG_GIO:  return split ? 16'h4800 : 16'h4000;
         default: return 16'h4000;
      endcase
   endfunction

   // log2 of the window size; repeats of short devices follow from it
   function automatic int rg_span(input int g, input bit split);
      case (g)
         RG_ROM:  return 15;
         RG_RAM:  return 14;
         RG_GIO:  return split ? 11 : 12;
         RG_SER:  return 11;
         default: return 12;
      endcase
   endfunction

   // the serial half exists only when the I/O window is split
   function automatic bit rg_exists(input int g, input bit split);
      return (g != RG_SER) || split;
   endfunction

   // only RAM is qualified by the bus clock
   function automatic bit rg_clocked(input int g);
      return g == RG_RAM;
   endfunction

endpackage

// File: rtl/mmap_window.sv
module mmap_window #(
   parameter int                 AW        = 16,
   parameter logic [AW-1:0]      BASE      = '0,
   parameter int                 SPAN_LOG2 = 12
) (
   input  logic [AW-1:0] addr,
   output logic          hit
);
   localparam logic [AW-1:0] LOW_ONES = AW'((64'd1 << SPAN_LOG2) - 64'd1);
   localparam logic [AW-1:0] KEEP     = ~LOW_ONES;

   if (SPAN_LOG2 < 0 || SPAN_LOG2 > AW) begin : g_bad_span
      $error("mmap_window: span outside address width");
   end
   if ((BASE & LOW_ONES) != '0) begin : g_bad_base
      $error("mmap_window: base not aligned to span");
   end

   assign hit = ((addr ^ BASE) & KEEP) == '0;

   always_comb begin
      if (hit) AST_HIT_ALIGNED: assert ((addr & KEEP) == BASE); // R3
   end
endmodule

// File: rtl/mmap_cs_drive.sv
module mmap_cs_drive (
   input  logic hit,
   input  logic en,
   input  logic qual,
   output logic cs_n
);
   assign cs_n = ~(hit & en & qual);

   always_comb begin
      if (!cs_n) AST_CS_NEEDS_HIT: assert (hit && en); // R7
   end
endmodule

// File: rtl/mmap_claim.sv
module mmap_claim #(
   parameter int N = 7
) (
   input  logic [N-1:0] hit,
   input  logic [N-1:0] fitted,
   output logic         unmapped
);
   logic [N-1:0] owned;
   assign owned    = hit & fitted;
   assign unmapped = (owned == '0);

   always_comb begin
      AST_SINGLE_OWNER: assert ($onehot0(owned)); // R6
   end
endmodule

// File: rtl/mmap_decoder.sv
module mmap_decoder
   import mmap_pkg::*;
#(
   parameter int              ADDR_W    = MAP_AW,
   parameter bit              SPLIT_IO  = 1'b1,
   parameter logic [NUM_RG-1:0] POPULATED = '1
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              phi2,
   output logic              rom_cs_n,
   output logic              ram_cs_n,
   output logic              snd_cs_n,
   output logic              disp_cs_n,
   output logic              keys_cs_n,
   output logic              gio_cs_n,
   output logic              ser_cs_n,
   output logic              unmapped
);
   if (ADDR_W != MAP_AW) begin : g_bad_width
      $error("mmap_decoder: map constants assume a 16-bit bus");
   end

   logic [NUM_RG-1:0] win_hit;
   logic [NUM_RG-1:0] fitted;
   logic [NUM_RG-1:0] cs_n_vec;

   for (genvar g = 0; g < NUM_RG; g++) begin : g_rg
      logic qual;

      mmap_window #(
         .AW        (ADDR_W),
         .BASE      (rg_base(g, SPLIT_IO)),
         .SPAN_LOG2 (rg_span(g, SPLIT_IO))
      ) u_win (
         .addr (addr),
         .hit  (win_hit[g])
      );

      assign fitted[g] = POPULATED[g] & rg_exists(g, SPLIT_IO);

      if (rg_clocked(g)) begin : g_qual
         assign qual = phi2;
      end else begin : g_free
         assign qual = 1'b1;
      end

      mmap_cs_drive u_drv (
         .hit  (win_hit[g] & rg_exists(g, SPLIT_IO)),
         .en   (fitted[g]),
         .qual (qual),
         .cs_n (cs_n_vec[g])
      );
   end

   mmap_claim #(.N(NUM_RG)) u_claim (
      .hit      (win_hit),
      .fitted   (fitted),
      .unmapped (unmapped)
   );

   assign rom_cs_n  = cs_n_vec[RG_ROM];
   assign ram_cs_n  = cs_n_vec[RG_RAM];
   assign snd_cs_n  = cs_n_vec[RG_SND];
   assign disp_cs_n = cs_n_vec[RG_DISP];
   assign keys_cs_n = cs_n_vec[RG_KEYS];
   assign gio_cs_n  = cs_n_vec[RG_GIO];
   assign ser_cs_n  = cs_n_vec[RG_SER];

   always_comb begin
      AST_AT_MOST_ONE_CS: assert ($onehot0(~cs_n_vec)); // R6
      if (!ram_cs_n) AST_RAM_IN_PHASE2: assert (phi2); // R2
      if (!ram_cs_n) AST_RAM_LOW_QUARTER: assert (addr[15:14] == 2'b00); // R2
      if (!rom_cs_n) AST_ROM_UPPER_HALF: assert (addr[15]); // R1
      if (!snd_cs_n) AST_SND_WINDOW: assert (addr[15:12] == 4'h7); // R3
      if (!ser_cs_n) AST_SER_LOW_HALF: assert (addr[15:11] == 5'b01000); // R4
      if (unmapped) AST_UNMAPPED_QUIET: assert (&cs_n_vec); // R7
      if (!SPLIT_IO) AST_MERGED_NO_SER: assert (ser_cs_n); // R5
   end
endmodule

// File: tb/mmap_decoder_tb.sv
module mmap_decoder_tb;
   localparam int CLK_PERIOD = 10;
   localparam logic [6:0] SPARSE_MASK = 7'b0111011;

   logic        clk = 1'b0;
   logic [15:0] addr = '0;
   int          vectors = 0;
   int          fails = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   logic [7:0] act_a, act_b, act_c;

   mmap_decoder u_dut (
      .addr(addr), .phi2(clk),
      .rom_cs_n(act_a[0]), .ram_cs_n(act_a[1]), .snd_cs_n(act_a[2]),
      .disp_cs_n(act_a[3]), .keys_cs_n(act_a[4]), .gio_cs_n(act_a[5]),
      .ser_cs_n(act_a[6]), .unmapped(act_a[7]));

   mmap_decoder #(.SPLIT_IO(1'b0)) u_dut_merged (
      .addr(addr), .phi2(clk),
      .rom_cs_n(act_b[0]), .ram_cs_n(act_b[1]), .snd_cs_n(act_b[2]),
      .disp_cs_n(act_b[3]), .keys_cs_n(act_b[4]), .gio_cs_n(act_b[5]),
      .ser_cs_n(act_b[6]), .unmapped(act_b[7]));

   mmap_decoder #(.POPULATED(SPARSE_MASK)) u_dut_sparse (
      .addr(addr), .phi2(clk),
      .rom_cs_n(act_c[0]), .ram_cs_n(act_c[1]), .snd_cs_n(act_c[2]),
      .disp_cs_n(act_c[3]), .keys_cs_n(act_c[4]), .gio_cs_n(act_c[5]),
      .ser_cs_n(act_c[6]), .unmapped(act_c[7]));

   // active-high view: bit 7 unmapped, bits 6..0 selects
   function automatic logic [7:0] view(input logic [7:0] raw);
      return {raw[7], ~raw[6:0]};
   endfunction

   function automatic logic [7:0] model(input int a, input bit p,
                                        input bit split, input logic [6:0] pop);
      logic [6:0] hit = '0;
      logic [6:0] sel;
      if (a >= 32768)      hit[0] = 1'b1;
      else if (a < 16384)  hit[1] = 1'b1;
      else if (a >= 28672) hit[2] = 1'b1;
      else if (a >= 24576) hit[3] = 1'b1;
      else if (a >= 20480) hit[4] = 1'b1;
      else if (!split)     hit[5] = 1'b1;
      else if (a >= 18432) hit[5] = 1'b1;
      else                 hit[6] = 1'b1;
      sel = hit & pop;
      if (!p) sel[1] = 1'b0;
      return {(hit & pop) == '0, sel};
   endfunction

   function automatic string tag_of(input int a);
      if (a >= 32768) return "R1";
      if (a < 16384)  return "R2";
      if (a >= 20480) return "R3";
      return "R4";
   endfunction

   task automatic chk(input string tag, input int a, input bit p,
                      input logic [7:0] act, input logic [7:0] exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s addr=%04h phi2=%0d actual=%08b expected=%08b",
                  tag, a, p, act, exp);
      end
   endtask

   task automatic sample(input int a, input bit p, input logic [7:0] hi_a);
      logic [7:0] va = view(act_a);
      logic [7:0] vb = view(act_b);
      logic [7:0] vc = view(act_c);
      chk(tag_of(a), a, p, va, model(a, p, 1'b1, 7'h7F));
      chk((a >= 16384 && a < 20480) ? "R5" : tag_of(a), a, p, vb,
          model(a, p, 1'b0, 7'h7F));
      chk("R7", a, p, vc, model(a, p, 1'b1, SPARSE_MASK));
      vectors++;
      if ($countones(va[6:0]) > 1 || (p && $countones(va) != 1)) begin
         fails++;
         $display("FAIL R6 addr=%04h phi2=%0d actual=%08b expected=one active",
                  a, p, va);
      end
      if (!p) begin
         vectors++;
         if ({va[7], va[6:2], va[0]} !== {hi_a[7], hi_a[6:2], hi_a[0]}) begin
            fails++;
            $display("FAIL R8 addr=%04h actual=%08b expected=%08b (ram bit ignored)",
                     a, va, hi_a);
         end
      end
   endtask

   task automatic run();
      // idle state: address 0 with phi2 low shows no select
      #(CLK_PERIOD/4);
      chk("R2", 0, 1'b0, view(act_a), 8'b0000_0000);
      for (int a = 0; a < 65536; a++) begin
         logic [7:0] hi;
         @(posedge clk);
         #1 addr = a[15:0];
         #(CLK_PERIOD/4);
         hi = view(act_a);
         sample(a, 1'b1, hi);
         @(negedge clk);
         #(CLK_PERIOD/4);
         sample(a, 1'b0, hi);
      end
   endtask

   initial begin
      fork
         run();
         begin
            repeat (150000) @(posedge clk);
            fails++;
            $display("FAIL watchdog expired before sweep end");
         end
      join_any
      disable fork;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end
endmodule